// File: doc/BRIEF.md
# Square-Wave Frequency Divider

This block derives a slow square wave from a fast system clock. The input clock rate and the wanted output rate are integer parameters, 40 MHz and 1.2 kHz by default. The block rounds the full output period to the nearest whole number of input cycles. When that number is odd, the high phase is one cycle longer than the low phase. The output comes straight from a flip-flop, so it can drive logic as a data signal or as a clock enable.

One down-counter times the two phases. Whenever the counter reaches zero, the output flips and the counter is reloaded with the length of the phase that has just begun. A two-stage reset synchronizer takes the active-low reset pin. Reset takes effect in the synchronizer as soon as the pin falls. The pin's release is aligned to the clock before the divider sees it. Both rates must give a rounded period of at least two cycles.

Top module: `sqwave_div`

## Requirements
- R1: With P = (IN_HZ + OUT_HZ/2) / OUT_HZ in integer division, every high phase of `wave_out` lasts exactly H = (P+1)/2 input cycles. With the default parameters, P = 33333 and H = 16667.
- R2: Every low phase of `wave_out` that does not begin in reset lasts exactly P − H input cycles. With the default parameters this is 16666.
- R3: A high phase plus the low phase that follows it spans exactly P cycles, so an odd P gives the extra cycle to the high phase. The output changes only on a clock edge at which the phase counter has expired.
- R4: While `rst_n` is low, `wave_out` is 0. It is 0 from the first rising clock edge after `rst_n` falls.
- R5: After `rst_n` rises between clock edges, `wave_out` stays 0 through the first two rising edges and becomes 1 on the third. A full-length high phase starts there.
- R6: If reset reaches the core on the same edge at which a phase would have ended, reset wins: `wave_out` is 0 after that edge. The first high phase after release still has full length H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock at IN_HZ |
| rst_n | input | 1 | Active-low reset; assertion is asynchronous, release is synchronized internally |
| wave_out | output | 1 | Registered square wave at about OUT_HZ |

## Verification
The two events that can land on the same clock edge are a synchronized reset and the expiry of the phase counter, which would otherwise flip the output and reload the counter. The bench provokes this collision by asserting reset at every offset from 0 to 11 cycles after a release. The short-period configurations (periods 2, 3, 10 and 11 cycles) are run together with the default one, so every phase position of those configurations meets a reset. Each collision is judged by three checks: the output must be low one edge after assertion, the output must rise on the third edge after release, and the next high run and the low run after it must have their full computed lengths.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  // Full period in input cycles, rounded to nearest
  function automatic int sqw_period(input int in_hz, input int out_hz);
    return (in_hz + out_hz / 2) / out_hz;
  endfunction

  // High phase takes the odd cycle
  function automatic int sqw_high(input int period);
    return (period + 1) / 2;
  endfunction

  function automatic int sqw_low(input int period);
    return period - sqw_high(period);
  endfunction

  // Counter width: enough bits to hold high-1, never zero
  function automatic int sqw_cnt_width(input int high);
    return (high <= 2) ? 1 : $clog2(high);
  endfunction

endpackage

// File: rtl/sqw_rst_sync.sv
module sqw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst = chain_q[STAGES-1];

endmodule

// File: rtl/sqw_half_timer.sv
module sqw_half_timer #(
  parameter int CW       = 15,
  parameter int HIGH_LEN = 2,
  parameter int LOW_LEN  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          level_i,
  output logic          expired_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] HI_LOAD = CW'(HIGH_LEN - 1);
  localparam logic [CW-1:0] LO_LOAD = CW'(LOW_LEN - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = (cnt_q == '0);
  assign count_o   = cnt_q;

  // Reload with the length of the phase the output is about to enter
  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (expired_o) cnt_q <= level_i ? LO_LOAD : HI_LOAD;
    else                cnt_q <= cnt_q - 1'b1;
  end

  // R1
  reload_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= HI_LOAD);

  // R2
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sqw_phase_reg.sv
module sqw_phase_reg (
  input  logic clk,
  input  logic rst,
  input  logic expired_i,
  output logic level_o
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (rst)            level_q <= 1'b0;
    else if (expired_i) level_q <= ~level_q;
  end

  assign level_o = level_q;

  // R3
  flip_on_expiry_chk: assert property (@(posedge clk) disable iff (rst)
    expired_i |=> (level_q != $past(level_q)));

  // R3
  steady_chk: assert property (@(posedge clk) disable iff (rst)
    !expired_i |=> $stable(level_q));

endmodule

// File: rtl/sqwave_div.sv
module sqwave_div #(
  parameter int IN_HZ  = 40_000_000,
  parameter int OUT_HZ = 1_200
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave_out
);
  import sqw_pkg::*;

  localparam int PERIOD   = sqw_period(IN_HZ, OUT_HZ);
  localparam int HIGH_LEN = sqw_high(PERIOD);
  localparam int LOW_LEN  = sqw_low(PERIOD);
  localparam int CW       = sqw_cnt_width(HIGH_LEN);

  logic          rst;
  logic          expired;
  logic          level;
  logic [CW-1:0] count;

  sqw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .rst    (rst)
  );

  sqw_half_timer #(
    .CW       (CW),
    .HIGH_LEN (HIGH_LEN),
    .LOW_LEN  (LOW_LEN)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .level_i   (level),
    .expired_o (expired),
    .count_o   (count)
  );

  sqw_phase_reg u_phase (
    .clk       (clk),
    .rst       (rst),
    .expired_i (expired),
    .level_o   (level)
  );

  assign wave_out = level;

  // R1
  high_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |-> (count == CW'(HIGH_LEN - 1)));

  // R2
  low_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(level) |-> (count == CW'(LOW_LEN - 1)));

endmodule

// File: tb/test_sqwave_div.sv
module test_sqwave_div;

  localparam int CLK_PERIOD = 10;
  localparam int NCFG = 5;
  localparam int IN_TAB [NCFG] = '{40_000_000, 100, 100, 100, 10};
  localparam int OUT_TAB[NCFG] = '{1_200,      10,  9,   40,  5};

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [NCFG-1:0] wave;

  int tests = 0, fails = 0;
  int mon_tests = 0, mon_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    sqwave_div #(.IN_HZ(IN_TAB[g]), .OUT_HZ(OUT_TAB[g])) i_sqwave_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .wave_out (wave[g])
    );
  end

  function automatic int exp_p(input int i);
    return (IN_TAB[i] + OUT_TAB[i] / 2) / OUT_TAB[i];
  endfunction
  function automatic int exp_h(input int i);
    return (exp_p(i) + 1) / 2;
  endfunction
  function automatic int exp_l(input int i);
    return exp_p(i) - exp_h(i);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input logic val, input string req, input string what);
    for (int i = 0; i < NCFG; i++)
      check(wave[i] === val, req, $sformatf("%s cfg%0d", what, i),
            int'(wave[i]), int'(val));
  endtask

  // Run-length monitor: measures every high and low run after a clean start
  int run_len[NCFG];
  int last_hi[NCFG];
  int hi_seen[NCFG];
  int lo_seen[NCFG];
  bit armed[NCFG];
  bit have_hi[NCFG];
  logic prev[NCFG];

  initial begin
    for (int i = 0; i < NCFG; i++) begin
      run_len[i] = 0; last_hi[i] = 0; hi_seen[i] = 0; lo_seen[i] = 0;
      armed[i] = 1'b0; have_hi[i] = 1'b0; prev[i] = 1'b0;
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NCFG; i++) begin
      if (!rst_n) begin
        armed[i] = 1'b0; have_hi[i] = 1'b0; run_len[i] = 0; prev[i] = wave[i];
      end else if (wave[i] === prev[i]) begin
        run_len[i]++;
      end else begin
        if (armed[i]) begin
          mon_tests++;
          if (prev[i] === 1'b1) begin
            hi_seen[i]++;
            if (run_len[i] != exp_h(i)) begin
              mon_fails++;
              $display("FAIL R1 high run cfg%0d: actual %0d expected %0d",
                       i, run_len[i], exp_h(i));
            end
            last_hi[i] = run_len[i];
            have_hi[i] = 1'b1;
          end else begin
            lo_seen[i]++;
            if (run_len[i] != exp_l(i)) begin
              mon_fails++;
              $display("FAIL R2 low run cfg%0d: actual %0d expected %0d",
                       i, run_len[i], exp_l(i));
            end
            if (have_hi[i]) begin
              mon_tests++;
              if (last_hi[i] + run_len[i] != exp_p(i)) begin
                mon_fails++;
                $display("FAIL R3 period cfg%0d: actual %0d expected %0d",
                         i, last_hi[i] + run_len[i], exp_p(i));
              end
            end
          end
        end else if (wave[i] === 1'b1) begin
          armed[i] = 1'b1;
        end
        run_len[i] = 1;
        prev[i] = wave[i];
      end
    end
  end

  task automatic release_and_check();
    #1 rst_n = 1'b1;
    @(negedge clk); check_all(1'b0, "R5", "low after 1st edge");
    @(negedge clk); check_all(1'b0, "R5", "low after 2nd edge");
    @(negedge clk); check_all(1'b1, "R5", "high after 3rd edge");
  endtask

  task automatic summary(input int extra_fail);
    $display("[TB] %0d tests run, %0d failed",
             tests + mon_tests, fails + mon_fails + extra_fail);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_all(1'b0, "R4", "reset state");
    release_and_check();
    // Long run: several full periods of the default configuration
    repeat (70000) @(negedge clk);
    // R6: reset meets every phase position of the short configurations
    for (int off = 0; off < 12; off++) begin
      repeat (off) @(negedge clk);
      #1 rst_n = 1'b0;
      @(negedge clk); check_all(1'b0, "R6", $sformatf("reset wins off%0d", off));
      repeat (2) @(negedge clk); check_all(1'b0, "R4", "held in reset");
      release_and_check();
    end
    repeat (400) @(negedge clk);
    for (int i = 0; i < NCFG; i++) begin
      check(hi_seen[i] > 0, "R1", $sformatf("high runs measured cfg%0d", i),
            hi_seen[i], 1);
      check(lo_seen[i] > 0, "R2", $sformatf("low runs measured cfg%0d", i),
            lo_seen[i], 1);
    end
    summary(0);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R5 watchdog expired: actual %0d expected %0d", 150000, 0);
    summary(1);
    $finish;
  end

endmodule